// File: doc/BRIEF.md
# Chained Vector Multiply-Add Pipeline

This block runs a dependent pair of vector operations on 64-bit fixed-point elements. For every index `i` below the active vector length it forms a product `P[i] = X[i] * S` (signed Q48.16, so the full product is shifted right by 16 and the low 64 bits are kept), then a sum `Z[i] = P[i] + Y[i]` (wrapping, modulo 2^64). `X` and `Y` are two 64-entry source banks loaded through a write port. `Z` is a 64-entry destination bank read back through a combinational read port. The scalar `S` arrives on an input and is captured when the operation starts.

The multiply unit has a start-up latency of 7 cycles and the add unit one of 6. Both are fully pipelined and take one element per clock. With chaining enabled, each product goes straight from the multiply output into the adder in the cycle it appears, so the two units overlap. With chaining disabled, the products are first parked in an internal product bank. The add starts only after the last product has been written, so the two operations run back to back. Software can time a run in either mode by watching `done`.

The controller is a state machine with six states. IDLE goes to DONE on a start with an effective length of 0, and goes to MUL_ISSUE on a start with any other length. MUL_ISSUE issues one multiply per cycle. After the last issue it goes to WAIT_SUM when chaining, and to MUL_DRAIN when not. MUL_DRAIN goes to ADD_ISSUE when the last product leaves the multiplier. ADD_ISSUE issues one add per cycle and goes to WAIT_SUM after the last one. WAIT_SUM goes to DONE when the last sum leaves the adder. DONE returns to IDLE after one cycle.

Top module: `vchain_unit`

## Requirements
- R1: While `ld_we` is high, a clock edge writes `ld_data` into bank X at `ld_idx` when `ld_sel`=0, or into bank Y when `ld_sel`=1. `rd_data` shows Z[`rd_idx`] combinationally. All banks read 0 after reset.
- R2: A start edge captures `vlen`, `scalar` and `chain_en`, and the run uses only these captured values. Each sum written is Y[i] + ((sign-extended X[i] * sign-extended scalar) arithmetically shifted right by 16), truncated to 64 bits.
- R3: A run of effective length n writes exactly n sums, at most one per cycle, with indices 0,1,…,n-1 in increasing order. Each write is shown on `wr_valid`/`wr_idx`/`wr_data` in the cycle it is written to Z.
- R4: With `chain_en`=1 captured, the first write appears 13 cycles after the start edge and `done` appears n+13 cycles after it.
- R5: With `chain_en`=0 captured, the first write appears n+13 cycles after the start edge and `done` appears 2n+13 cycles after it. No add is issued while a product is still leaving the multiplier.
- R6: A `vlen` of 0 makes no writes and gives `done` in the cycle right after the start edge.
- R7: A `vlen` above 64 is treated as 64.
- R8: A `start` that arrives while `busy` is high is ignored. The run in progress keeps its length, scalar, mode, results and timing.
- R9: `done` is a single-cycle pulse. `busy` is high from the cycle after an accepted start through the `done` cycle, and low after that.
- R10: Z entries at indices at or above the effective length keep their earlier contents after a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled only when idle) |
| chain_en | input | 1 | 1 = chained add, 0 = add after all products |
| vlen | input | 7 | Requested vector length, 0..127 |
| scalar | input | 64 | Q48.16 scalar multiplier |
| ld_we | input | 1 | Source bank write enable |
| ld_sel | input | 1 | 0 = bank X, 1 = bank Y |
| ld_idx | input | 6 | Source bank write index |
| ld_data | input | 64 | Source bank write data |
| rd_idx | input | 6 | Destination bank read index |
| rd_data | output | 64 | Destination bank read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | output | 1 | A sum is written this cycle |
| wr_idx | output | 6 | Index of the sum being written |
| wr_data | output | 64 | Value of the sum being written |

## Verification
The assertions assume that the source banks are not loaded while `busy` is high, and that `rst_n` is asserted before the first run. Under those conditions, the product bank and the destination write order depend only on the controller's own issue sequence. The stimulus loads X and Y only between runs. It starts a new run only after the previous `done`. It issues a stray `start` only in the middle of a long run, on purpose, to exercise R8.

// File: rtl/vc_pkg.sv
package vc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL_ISSUE,
        ST_MUL_DRAIN,
        ST_ADD_ISSUE,
        ST_WAIT_SUM,
        ST_DONE
    } vc_state_e;

endpackage

// File: rtl/vc_bank.sv
module vc_bank #(
    parameter int W     = 64,
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/vc_pipe.sv
module vc_pipe #(
    parameter int LAT = 7,
    parameter int IW  = 6,
    parameter int W   = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [IW-1:0] in_idx,
    input  logic [W-1:0]  in_data,
    output logic          out_valid,
    output logic [IW-1:0] out_idx,
    output logic [W-1:0]  out_data
);

    logic          v  [1:LAT];
    logic [IW-1:0] ix [1:LAT];
    logic [W-1:0]  d  [1:LAT];

    for (genvar g = 1; g <= LAT; g++) begin : g_stage
        if (g == 1) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) v[g] <= 1'b0;
                else        v[g] <= in_valid;
            end
            always_ff @(posedge clk) begin
                ix[g] <= in_idx;
                d[g]  <= in_data;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) v[g] <= 1'b0;
                else        v[g] <= v[g-1];
            end
            always_ff @(posedge clk) begin
                ix[g] <= ix[g-1];
                d[g]  <= d[g-1];
            end
        end
    end

    assign out_valid = v[LAT];
    assign out_idx   = ix[LAT];
    assign out_data  = d[LAT];

endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
    import vc_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int IW     = 6,
    parameter int CW     = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] vlen_in,
    input  logic          chain_in,
    input  logic          mul_out_valid,
    input  logic [IW-1:0] mul_out_idx,
    input  logic          add_out_valid,
    input  logic [IW-1:0] add_out_idx,
    output logic          accept,
    output logic          busy,
    output logic          done,
    output logic          mul_issue,
    output logic          add_issue,
    output logic          chain_mode,
    output logic [IW-1:0] cnt,
    output logic [IW-1:0] last_idx
);

    vc_state_e     state_q, state_d;
    logic [CW-1:0] eff_len;
    logic          cnt_at_last;

    // requested length limited to the bank depth
    assign eff_len     = (vlen_in > CW'(MAX_VL)) ? CW'(MAX_VL) : vlen_in;
    assign cnt_at_last = (cnt == last_idx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (eff_len == '0) ? ST_DONE : ST_MUL_ISSUE;
                end
            end
            ST_MUL_ISSUE: begin
                if (cnt_at_last) begin
                    state_d = chain_mode ? ST_WAIT_SUM : ST_MUL_DRAIN;
                end
            end
            ST_MUL_DRAIN: begin
                if (mul_out_valid && (mul_out_idx == last_idx)) begin
                    state_d = ST_ADD_ISSUE;
                end
            end
            ST_ADD_ISSUE: begin
                if (cnt_at_last) state_d = ST_WAIT_SUM;
            end
            ST_WAIT_SUM: begin
                if (add_out_valid && (add_out_idx == last_idx)) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Moore-style outputs
    always_comb begin
        accept    = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        mul_issue = 1'b0;
        add_issue = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_MUL_ISSUE: mul_issue = 1'b1;
            ST_MUL_DRAIN: ;
            ST_ADD_ISSUE: add_issue = 1'b1;
            ST_WAIT_SUM:  ;
            ST_DONE:      done = 1'b1;
            default:      busy = 1'b0;
        endcase
    end

    // run parameters and issue counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            last_idx   <= '0;
            chain_mode <= 1'b0;
        end else begin
            if (accept) begin
                cnt        <= '0;
                last_idx   <= IW'(eff_len - CW'(1));
                chain_mode <= chain_in;
            end else if (mul_issue || add_issue) begin
                cnt <= cnt_at_last ? '0 : cnt + IW'(1);
            end
        end
    end

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: once running, busy holds until the done cycle
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R6: zero length finishes in the next cycle
    a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (vlen_in == '0)) |=> done);

    // R8: a start while busy leaves the captured run parameters alone
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(last_idx) && $stable(chain_mode)));

endmodule

// File: rtl/vchain_unit.sv
module vchain_unit #(
    parameter int ELEM_W  = 64,
    parameter int MAX_VL  = 64,
    parameter int MUL_LAT = 7,
    parameter int ADD_LAT = 6,
    parameter int FRAC    = 16,
    localparam int IW     = $clog2(MAX_VL),
    localparam int CW     = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              chain_en,
    input  logic [CW-1:0]     vlen,
    input  logic [ELEM_W-1:0] scalar,
    input  logic              ld_we,
    input  logic              ld_sel,
    input  logic [IW-1:0]     ld_idx,
    input  logic [ELEM_W-1:0] ld_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [ELEM_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              wr_valid,
    output logic [IW-1:0]     wr_idx,
    output logic [ELEM_W-1:0] wr_data
);

    logic              accept, mul_issue, add_issue, chain_mode;
    logic [IW-1:0]     cnt, last_idx;
    logic [ELEM_W-1:0] scalar_q;

    logic [ELEM_W-1:0] x_rd, y_rd, p_rd;
    logic [IW-1:0]     y_raddr;

    logic                mul_out_valid;
    logic [IW-1:0]       mul_out_idx;
    logic [ELEM_W-1:0]   mul_out_data;
    logic signed [2*ELEM_W-1:0] full_prod;
    logic [ELEM_W-1:0]   prod;

    logic              add_in_valid;
    logic [IW-1:0]     add_in_idx;
    logic [ELEM_W-1:0] add_in_a, add_in_sum;
    logic              add_out_valid;
    logic [IW-1:0]     add_out_idx;
    logic [ELEM_W-1:0] add_out_data;

    vc_ctrl #(.MAX_VL(MAX_VL), .IW(IW), .CW(CW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .vlen_in       (vlen),
        .chain_in      (chain_en),
        .mul_out_valid (mul_out_valid),
        .mul_out_idx   (mul_out_idx),
        .add_out_valid (add_out_valid),
        .add_out_idx   (add_out_idx),
        .accept        (accept),
        .busy          (busy),
        .done          (done),
        .mul_issue     (mul_issue),
        .add_issue     (add_issue),
        .chain_mode    (chain_mode),
        .cnt           (cnt),
        .last_idx      (last_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      scalar_q <= '0;
        else if (accept) scalar_q <= scalar;
    end

    // source banks
    vc_bank #(.W(ELEM_W), .DEPTH(MAX_VL)) u_xbank (
        .clk(clk), .rst_n(rst_n),
        .we(ld_we && !ld_sel), .waddr(ld_idx), .wdata(ld_data),
        .raddr(cnt), .rdata(x_rd)
    );

    assign y_raddr = chain_mode ? mul_out_idx : cnt;

    vc_bank #(.W(ELEM_W), .DEPTH(MAX_VL)) u_ybank (
        .clk(clk), .rst_n(rst_n),
        .we(ld_we && ld_sel), .waddr(ld_idx), .wdata(ld_data),
        .raddr(y_raddr), .rdata(y_rd)
    );

    // multiply: signed fixed-point, rescaled by FRAC
    assign full_prod = $signed(x_rd) * $signed(scalar_q);
    assign prod      = ELEM_W'(full_prod >>> FRAC);

    vc_pipe #(.LAT(MUL_LAT), .IW(IW), .W(ELEM_W)) u_mulpipe (
        .clk(clk), .rst_n(rst_n),
        .in_valid(mul_issue), .in_idx(cnt), .in_data(prod),
        .out_valid(mul_out_valid), .out_idx(mul_out_idx), .out_data(mul_out_data)
    );

    // product bank, used when the add waits for the whole vector
    vc_bank #(.W(ELEM_W), .DEPTH(MAX_VL)) u_pbank (
        .clk(clk), .rst_n(rst_n),
        .we(mul_out_valid && !chain_mode), .waddr(mul_out_idx), .wdata(mul_out_data),
        .raddr(cnt), .rdata(p_rd)
    );

    // add source: forwarded product or parked product
    assign add_in_valid = chain_mode ? mul_out_valid : add_issue;
    assign add_in_idx   = chain_mode ? mul_out_idx   : cnt;
    assign add_in_a     = chain_mode ? mul_out_data  : p_rd;
    assign add_in_sum   = add_in_a + y_rd;

    vc_pipe #(.LAT(ADD_LAT), .IW(IW), .W(ELEM_W)) u_addpipe (
        .clk(clk), .rst_n(rst_n),
        .in_valid(add_in_valid), .in_idx(add_in_idx), .in_data(add_in_sum),
        .out_valid(add_out_valid), .out_idx(add_out_idx), .out_data(add_out_data)
    );

    // destination bank
    vc_bank #(.W(ELEM_W), .DEPTH(MAX_VL)) u_zbank (
        .clk(clk), .rst_n(rst_n),
        .we(add_out_valid), .waddr(add_out_idx), .wdata(add_out_data),
        .raddr(rd_idx), .rdata(rd_data)
    );

    assign wr_valid = add_out_valid;
    assign wr_idx   = add_out_idx;
    assign wr_data  = add_out_data;

    // write-order tracking for the checks below
    logic          wr_seen;
    logic [IW-1:0] prev_wr_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_seen     <= 1'b0;
            prev_wr_idx <= '0;
        end else if (accept) begin
            wr_seen <= 1'b0;
        end else if (wr_valid) begin
            wr_seen     <= 1'b1;
            prev_wr_idx <= wr_idx;
        end
    end

    // R3: sums leave in strictly increasing index order
    a_r3_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_seen) |-> (wr_idx == prev_wr_idx + IW'(1)));

    // R3: a run starts writing at index 0
    a_r3_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_seen) |-> (wr_idx == '0));

    // R3: no write beyond the captured length
    a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_idx <= last_idx));

    // R5: without chaining the adder never overlaps the multiplier output
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_mode && add_in_valid) |-> !mul_out_valid);

endmodule

// File: tb/vchain_unit_bench.sv
`timescale 1ns/1ps
module vchain_unit_bench;

    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        chain_en = 1'b0;
    logic [6:0]  vlen = '0;
    logic [63:0] scalar = '0;
    logic        ld_we = 1'b0;
    logic        ld_sel = 1'b0;
    logic [5:0]  ld_idx = '0;
    logic [63:0] ld_data = '0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        busy, done, wr_valid;
    logic [5:0]  wr_idx;
    logic [63:0] wr_data;

    always #2.5 clk = ~clk;

    vchain_unit u_vchain_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .chain_en(chain_en),
        .vlen(vlen), .scalar(scalar), .ld_we(ld_we), .ld_sel(ld_sel),
        .ld_idx(ld_idx), .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .busy(busy), .done(done), .wr_valid(wr_valid), .wr_idx(wr_idx),
        .wr_data(wr_data)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int c0     = 0;
    int wr_count = 0;
    int first_delta = 0;
    bit first_seen = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        int          idx;
        logic [63:0] data;
    } item_t;

    item_t       exp_q[$];
    logic [63:0] mx [N];
    logic [63:0] my [N];
    logic [63:0] mz [N];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [63:0] fxmul(input logic [63:0] a, input logic [63:0] b);
        logic signed [127:0] ea, eb, pr;
        ea = {{64{a[63]}}, a};
        eb = {{64{b[63]}}, b};
        pr = ea * eb;
        return pr[79:16];
    endfunction

    // monitor: pop and compare each write as it appears
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            item_t it;
            wr_count++;
            if (!first_seen) begin
                first_seen  = 1'b1;
                first_delta = cyc - c0;
            end
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected write idx", 64'(wr_idx), 64'hFFFF);
            end else begin
                it = exp_q.pop_front();
                check(wr_idx == it.idx[5:0], "R3", "write index", 64'(wr_idx), 64'(it.idx));
                check(wr_data == it.data, "R2", "sum value", wr_data, it.data);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc == 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic load(input bit sel, input int idx, input logic [63:0] data);
        @(negedge clk);
        ld_we = 1'b1; ld_sel = sel; ld_idx = idx[5:0]; ld_data = data;
        @(negedge clk);
        ld_we = 1'b0;
        if (sel) my[idx] = data;
        else     mx[idx] = data;
    endtask

    task automatic readback(input string req);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            rd_idx = i[5:0];
            #1;
            check(rd_data == mz[i], req, $sformatf("Z[%0d] readback", i), rd_data, mz[i]);
        end
    endtask

    task automatic run_op(input int n, input logic [63:0] s, input bit ch, input bit poke);
        int eff, it, delta, exp_done, exp_first;
        eff = (n > N) ? N : n;
        for (int i = 0; i < eff; i++) begin
            item_t e;
            e.idx  = i;
            e.data = my[i] + fxmul(mx[i], s);
            exp_q.push_back(e);
            mz[i] = e.data;
        end
        first_seen = 1'b0;
        wr_count   = 0;
        @(negedge clk);
        vlen = n[6:0]; scalar = s; chain_en = ch; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c0 = cyc;
        // disturb the inputs: the run must use the captured values (R2)
        scalar = ~s; chain_en = ~ch; vlen = 7'd3;
        it = 0;
        while (!done && it < 1000) begin
            @(negedge clk);
            it++;
            start = (poke && it == 5);   // R8: stray start while busy
        end
        start = 1'b0;
        delta = cyc - c0;
        exp_done  = (eff == 0) ? 0 : (ch ? eff + 13 : 2 * eff + 13);
        exp_first = ch ? 13 : eff + 13;
        check(done == 1'b1, "R9", "done seen", 64'(done), 64'd1);
        check(busy == 1'b1, "R9", "busy during done", 64'(busy), 64'd1);
        if (eff == 0)
            check(delta == exp_done, "R6", "zero-length done delay", 64'(delta), 64'(exp_done));
        else if (ch)
            check(delta == exp_done, "R4", "chained done delay", 64'(delta), 64'(exp_done));
        else
            check(delta == exp_done, "R5", "unchained done delay", 64'(delta), 64'(exp_done));
        @(negedge clk);
        check(done == 1'b0, "R9", "done falls", 64'(done), 64'd0);
        check(busy == 1'b0, "R9", "busy falls", 64'(busy), 64'd0);
        check(wr_count == eff, (n > N) ? "R7" : "R3", "write count", 64'(wr_count), 64'(eff));
        check(exp_q.size() == 0, "R3", "missing writes", 64'(exp_q.size()), 64'd0);
        if (eff > 0) begin
            check(first_delta == exp_first, ch ? "R4" : "R5", "first write delay",
                  64'(first_delta), 64'(exp_first));
        end
        exp_q.delete();
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mx[i] = 64'h0; my[i] = 64'h0; mz[i] = 64'h0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1, R9)
        check(busy == 1'b0, "R9", "reset busy", 64'(busy), 64'd0);
        check(done == 1'b0, "R9", "reset done", 64'(done), 64'd0);
        check(wr_valid == 1'b0, "R3", "reset wr_valid", 64'(wr_valid), 64'd0);
        rd_idx = 6'd5;
        #1;
        check(rd_data == 64'd0, "R1", "reset Z read", rd_data, 64'd0);

        // R1: load both source banks
        for (int i = 0; i < N; i++) begin
            load(1'b0, i, (64'(i) * 64'h0000_0013_4567_89AB) ^ (i[0] ? 64'hFFFF_F000_0000_0000 : 64'h0));
            load(1'b1, i, 64'h1234_5678 - 64'(i) * 64'h0000_0001_0000_0010);
        end
        load(1'b1, 63, 64'h7FFF_FFFF_FFFF_FFFF);   // forces a wrapping sum

        run_op(8, 64'h0000_0000_0002_8000, 1'b1, 1'b0);   // R4 chained, scalar 2.5
        readback("R1");
        run_op(8, 64'hFFFF_FFFF_FFFF_0000, 1'b0, 1'b0);   // R5 unchained, scalar -1
        run_op(1, 64'h0000_0000_0000_C000, 1'b1, 1'b0);   // R4 single element
        run_op(1, 64'h0000_0000_0003_0000, 1'b0, 1'b0);   // R5 single element
        run_op(0, 64'h0000_0000_0001_0000, 1'b1, 1'b0);   // R6 zero length
        readback("R6");
        run_op(20, 64'h0000_0000_0001_4000, 1'b1, 1'b1);  // R8 stray start
        readback("R8");
        run_op(100, 64'hFFFF_FFFF_FFFE_8000, 1'b1, 1'b0); // R7 clamp to 64
        run_op(64, 64'h0000_0000_0000_8000, 1'b0, 1'b0);  // R5 full length
        for (int i = 0; i < 5; i++) begin
            load(1'b0, i, 64'h0000_0000_0100_0000 + 64'(i));
        end
        run_op(5, 64'h0000_0000_0002_0000, 1'b1, 1'b0);
        readback("R10");                                   // R10: Z[5..63] kept

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule